// File: doc/BRIEF.md
# Dual-Issue Hazard and Stall Logic

This block makes the issue decision at the decode stage of an in-order, two-wide pipeline with full bypassing. Each cycle it looks at the pair of instructions waiting in the fetch/decode latch and at the two older instructions that were issued one cycle earlier. For each instruction in the pair it has the register sources, the destination, the write flag and the load/store class. From these it decides which slots may issue in that same cycle and tells the fetch side whether the latch has to hold.

The block owns the decode/execute latch. Every clock edge it loads that latch with the issued instructions, or with bubbles where a slot was held back. The older-instruction state used for the load-use check is therefore the block's own registered output. Four kinds of hazard are checked:

- a load in decode/execute whose result a decoding instruction needs, checked across all four younger/older slot pairs;
- a true dependence between the two co-fetched instructions;
- a pair that holds more than one memory operation;
- the in-order rule, which the issue decision always keeps.

Top module: `dual_issue_hazard`

## Requirements
- R1: A decoding slot is held back when a valid decode/execute entry with load=1, write=1 and a destination other than r0 has its destination equal to that slot's rs1 or rs2.
- R2: The load-use check of R1 applies to every combination of decoding slot (0, 1) and older slot (0, 1), and to both sources of each decoding slot.
- R3: Slot 1 is held back when its rs1 or rs2 equals the destination of slot 0, provided slot 0 has write=1 and a destination other than r0.
- R4: An older instruction that is not a load never holds back a decoding instruction, even when its destination matches a source of that instruction.
- R5: When both slots are memory operations (load=1 or store=1), slot 1 is held back. Only one memory operation issues per cycle.
- R6: An instruction with write=0 never acts as a producer, neither in decode/execute nor as slot 0 of the pair.
- R7: A destination of r0 (index 0) never acts as a producer.
- R8: Issue is in order. Slot 1 issues only if slot 0 issues, and hazards of slot 1 never hold back slot 0. A valid slot 1 implies a valid slot 0.
- R9: At each clock edge, decode/execute slot j takes slot j's destination, write flag and load flag, with valid=1, when slot j issues. Otherwise it takes a bubble: valid=0, write=0, load=0, destination 0. Reset clears all entries to bubbles.
- R10: In the same cycle, fetch_stall is 1 exactly when a valid decoding slot does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fd_vld | input | 2 | Valid per decoding slot |
| fd_rs1 | input | 2x5 | First source register per slot |
| fd_rs2 | input | 2x5 | Second source register per slot |
| fd_rd | input | 2x5 | Destination register per slot |
| fd_wen | input | 2 | Register write flag per slot |
| fd_load | input | 2 | Slot is a load |
| fd_store | input | 2 | Slot is a store |
| issue_en | output | 2 | Slot issues this cycle |
| fetch_stall | output | 1 | Fetch/decode latch must hold |
| dx_vld | output | 2 | Decode/execute entry valid |
| dx_rd | output | 2x5 | Decode/execute destination |
| dx_wen | output | 2 | Decode/execute write flag |
| dx_load | output | 2 | Decode/execute load flag |

## Verification
Some properties are checked by assertions on every cycle:

- slot 1 never issues without slot 0;
- a pair of memory operations never issues together;
- no slot issues against a matching older load;
- a held-back slot always leaves a bubble in decode/execute;
- reset clears that latch.

Other behaviour can only be shown by the bench's scenarios:

- that harmless cases still issue: non-load producers, write=0 producers, r0 destinations and independent slot 0 instructions;
- the exact decode/execute contents after a dual issue;
- recovery of a stalled consumer one cycle later.

// File: rtl/dih_pkg.sv
package dih_pkg;
  parameter int REG_AW  = 5;
  parameter int ISSUE_W = 2;
  typedef logic [REG_AW-1:0] reg_idx_t;
endpackage

// File: rtl/dih_loaduse_xchk.sv
module dih_loaduse_xchk
  import dih_pkg::*;
(
  input  reg_idx_t [ISSUE_W-1:0] fd_rs1,
  input  reg_idx_t [ISSUE_W-1:0] fd_rs2,
  input  reg_idx_t [ISSUE_W-1:0] dx_rd,
  input  logic     [ISSUE_W-1:0] dx_vld,
  input  logic     [ISSUE_W-1:0] dx_wen,
  input  logic     [ISSUE_W-1:0] dx_load,
  output logic     [ISSUE_W-1:0] lu_block
);
  logic [ISSUE_W-1:0]              ld_prod;
  logic [ISSUE_W-1:0][ISSUE_W-1:0] term;   // [younger][older]

  genvar k, j;
  generate
    for (k = 0; k < ISSUE_W; k++) begin : g_prod
      assign ld_prod[k] = dx_vld[k] & dx_wen[k] & dx_load[k] & (dx_rd[k] != '0);
    end
    for (j = 0; j < ISSUE_W; j++) begin : g_young
      for (k = 0; k < ISSUE_W; k++) begin : g_old
        assign term[j][k] = ld_prod[k] &
                            ((fd_rs1[j] == dx_rd[k]) | (fd_rs2[j] == dx_rd[k]));
      end
      assign lu_block[j] = |term[j];
    end
  endgenerate
endmodule

// File: rtl/dih_pair_chk.sv
module dih_pair_chk
  import dih_pkg::*;
(
  input  reg_idx_t [ISSUE_W-1:1] yng_rs1,
  input  reg_idx_t [ISSUE_W-1:1] yng_rs2,
  input  reg_idx_t [ISSUE_W-2:0] old_rd,
  input  logic     [ISSUE_W-2:0] old_wen,
  input  logic     [ISSUE_W-1:0] slot_mem,
  output logic     [ISSUE_W-1:1] pair_block
);
  logic [ISSUE_W-2:0]              prod;
  logic [ISSUE_W-1:1][ISSUE_W-2:0] dep;
  logic [ISSUE_W-1:1][ISSUE_W-2:0] memc;

  genvar i, j;
  generate
    for (i = 0; i < ISSUE_W-1; i++) begin : g_prod
      assign prod[i] = old_wen[i] & (old_rd[i] != '0);
    end
    for (j = 1; j < ISSUE_W; j++) begin : g_yng
      for (i = 0; i < ISSUE_W-1; i++) begin : g_old
        if (i < j) begin : g_live
          assign dep[j][i]  = prod[i] &
                              ((yng_rs1[j] == old_rd[i]) | (yng_rs2[j] == old_rd[i]));
          assign memc[j][i] = slot_mem[i] & slot_mem[j];
        end else begin : g_dead
          assign dep[j][i]  = 1'b0;
          assign memc[j][i] = 1'b0;
        end
      end
      assign pair_block[j] = (|dep[j]) | (|memc[j]);
    end
  endgenerate
endmodule

// File: rtl/dih_issue_ctl.sv
module dih_issue_ctl
  import dih_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ISSUE_W-1:0] fd_vld,
  input  logic [ISSUE_W-1:0] lu_block,
  input  logic [ISSUE_W-1:1] pair_block,
  output logic [ISSUE_W-1:0] issue_en,
  output logic               fetch_stall
);
  assign issue_en[0] = fd_vld[0] & ~lu_block[0];

  genvar j;
  generate
    for (j = 1; j < ISSUE_W; j++) begin : g_chain
      assign issue_en[j] = fd_vld[j] & ~lu_block[j] & ~pair_block[j] & issue_en[j-1];

      AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        issue_en[j] |-> issue_en[j-1]); // R8
    end
  endgenerate

  assign fetch_stall = |(fd_vld & ~issue_en);
endmodule

// File: rtl/dih_dx_latch.sv
module dih_dx_latch
  import dih_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic     [ISSUE_W-1:0] issue_en,
  input  reg_idx_t [ISSUE_W-1:0] fd_rd,
  input  logic     [ISSUE_W-1:0] fd_wen,
  input  logic     [ISSUE_W-1:0] fd_load,
  output logic     [ISSUE_W-1:0] dx_vld,
  output reg_idx_t [ISSUE_W-1:0] dx_rd,
  output logic     [ISSUE_W-1:0] dx_wen,
  output logic     [ISSUE_W-1:0] dx_load
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dx_vld  <= '0;
      dx_rd   <= '0;
      dx_wen  <= '0;
      dx_load <= '0;
    end else begin
      for (int j = 0; j < ISSUE_W; j++) begin
        dx_vld[j]  <= issue_en[j];
        dx_wen[j]  <= issue_en[j] & fd_wen[j];
        dx_load[j] <= issue_en[j] & fd_load[j];
        dx_rd[j]   <= issue_en[j] ? fd_rd[j] : '0;
      end
    end
  end

  genvar j;
  generate
    for (j = 0; j < ISSUE_W; j++) begin : g_chk
      AST_BUBBLE_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
        !issue_en[j] |=> (!dx_vld[j] && !dx_wen[j] && !dx_load[j])); // R9
    end
  endgenerate

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dx_vld == '0 && dx_wen == '0 && dx_load == '0)); // R9
endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard
  import dih_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ISSUE_W-1:0]              fd_vld,
  input  logic [ISSUE_W-1:0][REG_AW-1:0]  fd_rs1,
  input  logic [ISSUE_W-1:0][REG_AW-1:0]  fd_rs2,
  input  logic [ISSUE_W-1:0][REG_AW-1:0]  fd_rd,
  input  logic [ISSUE_W-1:0]              fd_wen,
  input  logic [ISSUE_W-1:0]              fd_load,
  input  logic [ISSUE_W-1:0]              fd_store,
  output logic [ISSUE_W-1:0]              issue_en,
  output logic                            fetch_stall,
  output logic [ISSUE_W-1:0]              dx_vld,
  output logic [ISSUE_W-1:0][REG_AW-1:0]  dx_rd,
  output logic [ISSUE_W-1:0]              dx_wen,
  output logic [ISSUE_W-1:0]              dx_load
);
  logic [ISSUE_W-1:0] lu_block;
  logic [ISSUE_W-1:1] pair_block;
  logic [ISSUE_W-1:0] slot_mem;

  assign slot_mem = fd_load | fd_store;

  dih_loaduse_xchk u_lu (
    .fd_rs1   (fd_rs1),
    .fd_rs2   (fd_rs2),
    .dx_rd    (dx_rd),
    .dx_vld   (dx_vld),
    .dx_wen   (dx_wen),
    .dx_load  (dx_load),
    .lu_block (lu_block)
  );

  dih_pair_chk u_pair (
    .yng_rs1    (fd_rs1[ISSUE_W-1:1]),
    .yng_rs2    (fd_rs2[ISSUE_W-1:1]),
    .old_rd     (fd_rd[ISSUE_W-2:0]),
    .old_wen    (fd_wen[ISSUE_W-2:0]),
    .slot_mem   (slot_mem),
    .pair_block (pair_block)
  );

  dih_issue_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .fd_vld      (fd_vld),
    .lu_block    (lu_block),
    .pair_block  (pair_block),
    .issue_en    (issue_en),
    .fetch_stall (fetch_stall)
  );

  dih_dx_latch u_dx (
    .clk      (clk),
    .rst      (rst),
    .issue_en (issue_en),
    .fd_rd    (fd_rd),
    .fd_wen   (fd_wen),
    .fd_load  (fd_load),
    .dx_vld   (dx_vld),
    .dx_rd    (dx_rd),
    .dx_wen   (dx_wen),
    .dx_load  (dx_load)
  );

  AST_MEM_PORT: assert property (@(posedge clk) disable iff (rst)
    (slot_mem[0] && slot_mem[1]) |-> !issue_en[1]); // R5

  genvar j, k;
  generate
    for (j = 0; j < ISSUE_W; j++) begin : g_aj
      for (k = 0; k < ISSUE_W; k++) begin : g_ak
        AST_NO_LOAD_USE_ISSUE: assert property (@(posedge clk) disable iff (rst)
          (dx_vld[k] && dx_load[k] && dx_wen[k] && dx_rd[k] != '0 &&
           (fd_rs1[j] == dx_rd[k] || fd_rs2[j] == dx_rd[k])) |-> !issue_en[j]); // R1
      end
    end
  endgenerate
endmodule

// File: tb/dual_issue_hazard_bench.sv
`timescale 1ns/1ps
module dual_issue_hazard_bench;
  import dih_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]        fd_vld = '0, fd_wen = '0, fd_load = '0, fd_store = '0;
  logic [1:0][4:0]   fd_rs1 = '0, fd_rs2 = '0, fd_rd = '0;
  logic [1:0]        issue_en, dx_vld, dx_wen, dx_load;
  logic              fetch_stall;
  logic [1:0][4:0]   dx_rd;

  logic [1:0]        m_vld, m_wen, m_load;
  logic [1:0][4:0]   m_rd;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dual_issue_hazard u_dual_issue_hazard (
    .clk(clk), .rst(rst), .fd_vld(fd_vld), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2),
    .fd_rd(fd_rd), .fd_wen(fd_wen), .fd_load(fd_load), .fd_store(fd_store),
    .issue_en(issue_en), .fetch_stall(fetch_stall), .dx_vld(dx_vld),
    .dx_rd(dx_rd), .dx_wen(dx_wen), .dx_load(dx_load)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic lu_hit(input int j);
    logic h = 1'b0;
    for (int k = 0; k < 2; k++)
      if (m_vld[k] && m_wen[k] && m_load[k] && m_rd[k] != 5'd0 &&
          (fd_rs1[j] == m_rd[k] || fd_rs2[j] == m_rd[k])) h = 1'b1;
    return h;
  endfunction

  task automatic step(input string tag);
    logic [1:0] e;
    logic dep, memc, st;
    #1;
    dep  = fd_wen[0] && fd_rd[0] != 5'd0 &&
           (fd_rs1[1] == fd_rd[0] || fd_rs2[1] == fd_rd[0]);
    memc = (fd_load[0] | fd_store[0]) & (fd_load[1] | fd_store[1]);
    e[0] = fd_vld[0] & ~lu_hit(0);
    e[1] = fd_vld[1] & ~lu_hit(1) & ~dep & ~memc & e[0];
    st   = (fd_vld[0] & ~e[0]) | (fd_vld[1] & ~e[1]);
    chk(tag, "issue_en", {30'd0, issue_en}, {30'd0, e});
    chk("R10", "fetch_stall", {31'd0, fetch_stall}, {31'd0, st});
    chk("R9", "dx_state", {16'd0, dx_vld, dx_wen, dx_load, dx_rd},
                          {16'd0, m_vld, m_wen, m_load, m_rd});
    @(posedge clk);
    for (int j = 0; j < 2; j++) begin
      m_vld[j]  = e[j];
      m_wen[j]  = e[j] & fd_wen[j];
      m_load[j] = e[j] & fd_load[j];
      m_rd[j]   = e[j] ? fd_rd[j] : 5'd0;
    end
    @(negedge clk);
  endtask

  task automatic put(input int j, input logic v, input int s1, input int s2,
                     input int d, input logic w, input logic ld, input logic sto);
    fd_vld[j] = v; fd_rs1[j] = 5'(s1); fd_rs2[j] = 5'(s2); fd_rd[j] = 5'(d);
    fd_wen[j] = w; fd_load[j] = ld; fd_store[j] = sto;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_vld = '0; m_wen = '0; m_load = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R9", "reset_dx", {30'd0, dx_vld}, 32'd0);
    chk("R9", "reset_issue", {30'd0, issue_en}, 32'd0);

    // load r3 plus independent alu: dual issue
    put(0, 1, 1, 2, 3, 1, 1, 0); put(1, 1, 4, 5, 6, 1, 0, 0); step("R9");
    // consumer of r3 in slot 0 holds both
    put(0, 1, 3, 7, 8, 1, 0, 0); put(1, 1, 9, 10, 11, 1, 0, 0); step("R1");
    step("R8");                                            // bubble gone, issues
    // load in older slot 1, consumer in slot 1 via rs2
    put(0, 1, 1, 1, 12, 1, 0, 0); put(1, 1, 2, 2, 13, 1, 1, 0); step("R2");
    put(0, 1, 1, 2, 14, 1, 0, 0); put(1, 1, 4, 13, 15, 1, 0, 0); step("R2");
    // older slot 1 load, consumer in slot 0 via rs2
    put(0, 1, 1, 1, 16, 1, 0, 0); put(1, 1, 2, 2, 17, 1, 1, 0); step("R2");
    put(0, 1, 5, 17, 18, 1, 0, 0); put(1, 1, 4, 4, 19, 1, 0, 0); step("R2");
    // non-load producer in older stage
    put(0, 1, 1, 1, 20, 1, 0, 0); put(1, 0, 0, 0, 0, 0, 0, 0); step("R4");
    put(0, 1, 20, 20, 21, 1, 0, 0); step("R4");
    // intra-pair dependence
    put(0, 1, 1, 2, 9, 1, 0, 0); put(1, 1, 9, 3, 22, 1, 0, 0); step("R3");
    put(0, 1, 1, 2, 9, 1, 0, 0); put(1, 1, 3, 9, 22, 1, 0, 0); step("R3");
    // memory port limit
    put(0, 1, 1, 2, 0, 0, 0, 1); put(1, 1, 4, 5, 23, 1, 1, 0); step("R5");
    put(0, 1, 1, 2, 24, 1, 1, 0); put(1, 1, 4, 5, 25, 1, 0, 0); step("R5");
    // write=0 producers
    put(0, 1, 1, 2, 10, 0, 0, 1); put(1, 1, 10, 10, 26, 1, 0, 0); step("R6");
    put(0, 1, 1, 2, 11, 0, 1, 0); put(1, 0, 0, 0, 0, 0, 0, 0); step("R6");
    put(0, 1, 11, 11, 27, 1, 0, 0); step("R6");
    // r0 destinations
    put(0, 1, 1, 2, 0, 1, 1, 0); put(1, 0, 0, 0, 0, 0, 0, 0); step("R7");
    put(0, 1, 0, 0, 0, 1, 0, 0); put(1, 1, 0, 0, 28, 1, 0, 0); step("R7");
    // in-order: slot 0 blocked, slot 1 independent
    put(0, 1, 1, 2, 29, 1, 1, 0); put(1, 0, 0, 0, 0, 0, 0, 0); step("R8");
    put(0, 1, 29, 1, 30, 1, 0, 0); put(1, 1, 2, 3, 31, 1, 0, 0); step("R8");

    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      for (int j = 0; j < 2; j++) begin
        logic [3:0] c = 4'($urandom_range(0, 15));
        put(j, (j == 0) ? (c != 0) : (fd_vld[0] && c[0]),
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            c[1] | c[2], c[2] & c[3], c[3] & ~c[2]);
      end
      step("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule